// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked system and an external asynchronous static RAM holding 262,144 words of 16 bits. A requester offers one word access at a time: an 18-bit word address, a read or write flag, 16 bits of write data and a 2-bit byte mask. The controller then produces the memory's active-low strobes for that access: chip select, write strobe, output enable and one enable per byte lane. It also steers the direction of the shared data bus, and it answers each access with a one-cycle done pulse. For a read, the pulse comes with the registered data word.

All analogue timing limits of the memory are expressed as clock-cycle counts set by parameters. These cover the read access wait, the width of the write-strobe pulse, how long write data is set up before the write strobe rises, the idle gap after a read before the bus may be driven again, and the wait after power-up. A write is always ended by the write strobe rising while chip select stays low. The controller stops driving the bus in that same cycle. Write data is put on the bus only late in the pulse, so the memory has released its own drivers first. The pins are split into separate data-in, data-out and output-enable signals so that the pad ring can build the bidirectional pad.

Top module: `sram_ctrl`

## Requirements
- R1: After reset, `req_ready` stays low and every strobe stays high, with `sram_dq_oe` low, for exactly PWRUP_CYC clock edges. `req_ready` is first seen high after edge number PWRUP_CYC, and no request is taken before then.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` drops after that edge. A request held while `req_ready` is low has no effect on memory contents.
- R3: A read holds chip select and output enable low and the write strobe high for exactly RD_WAIT_CYC+1 cycles. Its done pulse follows the accepting edge by RD_WAIT_CYC+1 edges.
- R4: `rsp_valid` is high for one cycle only. For a read, `rsp_rdata` then holds the addressed word, and any lane whose mask bit is 0 reads as zero.
- R5: A write has one cycle with chip select low and the write strobe high. Then the write strobe is low for exactly WE_PULSE_CYC cycles. Then there is one more cycle with chip select low and the write strobe high. Output enable is high for the whole write. The done pulse follows the accepting edge by WE_PULSE_CYC+2 edges.
- R6: `sram_dq_oe` is high only during the last DATA_SETUP_CYC cycles of the write-strobe pulse, and never in its first cycle. It is low in the cycle where the write strobe rises.
- R7: Mask bit 0 selects data bits 7:0 and `sram_be_n[0]`. Mask bit 1 selects bits 15:8 and `sram_be_n[1]`. During an access, `sram_be_n[i]` equals the inverse of mask bit i. A byte whose mask bit is 0 stays unchanged in memory, and a mask of 0 changes nothing.
- R8: After output enable was low, the bus is not driven for at least TURN_CYC cycles. After a read, output enable stays high for TURN_CYC cycles before `req_ready` returns.
- R9: While chip select is low on two consecutive cycles, the address and the byte enables do not change. Chip select returns high between any two accesses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte mask, bit 0 = low byte, bit 1 = high byte |
| rsp_valid | output | 1 | One-cycle done pulse |
| rsp_rdata | output | 16 | Read data, valid with the done pulse of a read |
| sram_addr | output | 18 | Memory address pins |
| sram_ce_n | output | 1 | Chip select, active low |
| sram_we_n | output | 1 | Write strobe, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_be_n | output | 2 | Byte lane enables, active low, bit 1 = high byte |
| sram_dq_out | output | 16 | Data driven toward the memory |
| sram_dq_oe | output | 1 | Controller drives the data bus when high |
| sram_dq_in | input | 16 | Data bus as seen from the memory |

## Verification
The bench builds the controller with a 3-cycle read wait, a 4-cycle write-strobe pulse, a 2-cycle data setup, a 2-cycle turnaround and a 20-cycle power-up wait. The short power-up lets the start-up gate and the ignored early request be checked quickly, ahead of a long mixed random run. A data setup two cycles shorter than the pulse means a correct design leaves the first strobe-low cycle undriven, so a bus clash with the memory can be seen. The behavioural memory shows garbage until the full read wait has passed. Lanes that are not selected float with a fixed pattern, so any shortened wait or missing mask changes the returned data.

// File: rtl/sramc_pkg.sv
package sramc_pkg;

    typedef enum logic [2:0] {
        ST_INIT,
        ST_IDLE,
        ST_RD_WAIT,
        ST_RD_CAP,
        ST_WR_SETUP,
        ST_WR_PULSE,
        ST_WR_REL,
        ST_TURN
    } sramc_state_e;

    typedef struct packed {
        logic ce_n;
        logic we_n;
        logic oe_n;
    } sramc_strobe_t;

    function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                         input int unsigned c, input int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

    function automatic sramc_strobe_t strobes_for(input sramc_state_e s);
        sramc_strobe_t r;
        r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        case (s)
            ST_RD_WAIT, ST_RD_CAP: r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b0};
            ST_WR_SETUP, ST_WR_REL: r = '{ce_n: 1'b0, we_n: 1'b1, oe_n: 1'b1};
            ST_WR_PULSE: r = '{ce_n: 1'b0, we_n: 1'b0, oe_n: 1'b1};
            default: r = '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
        endcase
        return r;
    endfunction

    function automatic logic state_selects(input sramc_state_e s);
        return (s == ST_RD_WAIT) || (s == ST_RD_CAP) || (s == ST_WR_SETUP) ||
               (s == ST_WR_PULSE) || (s == ST_WR_REL);
    endfunction

endpackage

// File: rtl/sramc_timer.sv
module sramc_timer #(
    parameter int W        = 8,
    parameter int INIT_VAL = 0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         zero
);
    always_ff @(posedge clk) begin
        if (rst)             cnt <= W'(INIT_VAL);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);

    AST_TMR_STICKY_ZERO: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero); // R1
endmodule

// File: rtl/sramc_lanes.sv
module sramc_lanes #(
    parameter int LANES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               capture,
    input  logic [LANES-1:0]   lane_en,
    input  logic [LANES*8-1:0] dq_in,
    output logic [LANES*8-1:0] rdata
);
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst)          rdata[l*8 +: 8] <= '0;
            else if (capture) rdata[l*8 +: 8] <= lane_en[l] ? dq_in[l*8 +: 8] : 8'h00;
        end

        AST_LANE_MASKED_ZERO: assert property (@(posedge clk) disable iff (rst)
            (capture && !lane_en[l]) |=> (rdata[l*8 +: 8] == 8'h00)); // R4
    end
endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
    import sramc_pkg::*;
#(
    parameter int ADDR_W         = 18,
    parameter int DATA_W         = 16,
    parameter int RD_WAIT_CYC    = 2,
    parameter int WE_PULSE_CYC   = 3,
    parameter int DATA_SETUP_CYC = 2,
    parameter int TURN_CYC       = 2,
    parameter int PWRUP_CYC      = 200000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_be,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     sram_addr,
    output logic                  sram_ce_n,
    output logic                  sram_we_n,
    output logic                  sram_oe_n,
    output logic [DATA_W/8-1:0]   sram_be_n,
    output logic [DATA_W-1:0]     sram_dq_out,
    output logic                  sram_dq_oe,
    input  logic [DATA_W-1:0]     sram_dq_in
);
    localparam int LANES = DATA_W / 8;
    localparam int CNT_W = $clog2(max4(PWRUP_CYC, RD_WAIT_CYC, WE_PULSE_CYC, TURN_CYC) + 1);

    sramc_state_e   state_q, state_d;
    sramc_strobe_t  strb_q;
    logic           tmr_load, tmr_zero, capture, accept, drive_d;
    logic [CNT_W-1:0] tmr_val, tmr_cnt;
    logic [LANES-1:0] mask_q, mask_d;

    sramc_timer #(.W(CNT_W), .INIT_VAL(PWRUP_CYC - 1)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val),
        .cnt(tmr_cnt), .zero(tmr_zero)
    );

    sramc_lanes #(.LANES(LANES)) u_lanes (
        .clk(clk), .rst(rst), .capture(capture), .lane_en(mask_q),
        .dq_in(sram_dq_in), .rdata(rsp_rdata)
    );

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign mask_d = accept ? req_be : mask_q;

    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        capture  = 1'b0;
        case (state_q)
            ST_INIT:     if (tmr_zero) state_d = ST_IDLE;
            ST_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        state_d = ST_WR_SETUP;
                    end else begin
                        state_d  = ST_RD_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_WAIT_CYC - 1);
                    end
                end
            end
            ST_RD_WAIT:  if (tmr_zero) state_d = ST_RD_CAP;
            ST_RD_CAP: begin
                capture  = 1'b1;
                state_d  = ST_TURN;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(TURN_CYC - 1);
            end
            ST_TURN:     if (tmr_zero) state_d = ST_IDLE;
            ST_WR_SETUP: begin
                state_d  = ST_WR_PULSE;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(WE_PULSE_CYC - 1);
            end
            ST_WR_PULSE: if (tmr_zero) state_d = ST_WR_REL;
            ST_WR_REL:   state_d = ST_IDLE;
            default:     state_d = ST_IDLE;
        endcase
    end

    // Next cycle drives data when the pulse continues and lands inside the setup window.
    assign drive_d = (state_q == ST_WR_PULSE) && !tmr_zero &&
                     (tmr_cnt <= CNT_W'(DATA_SETUP_CYC));

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_INIT;
            strb_q      <= '{ce_n: 1'b1, we_n: 1'b1, oe_n: 1'b1};
            mask_q      <= '0;
            sram_be_n   <= '1;
            sram_addr   <= '0;
            sram_dq_out <= '0;
            sram_dq_oe  <= 1'b0;
            req_ready   <= 1'b0;
            rsp_valid   <= 1'b0;
        end else begin
            state_q    <= state_d;
            strb_q     <= strobes_for(state_d);
            mask_q     <= mask_d;
            sram_be_n  <= state_selects(state_d) ? ~mask_d : '1;
            sram_dq_oe <= drive_d;
            req_ready  <= (state_d == ST_IDLE);
            rsp_valid  <= (state_q == ST_RD_CAP) || (state_q == ST_WR_REL);
            if (accept) begin
                sram_addr   <= req_addr;
                sram_dq_out <= req_wdata;
            end
        end
    end

    assign sram_ce_n = strb_q.ce_n;
    assign sram_we_n = strb_q.we_n;
    assign sram_oe_n = strb_q.oe_n;

    AST_QUIET_IN_INIT: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_INIT) |-> (sram_ce_n && !sram_dq_oe && !req_ready)); // R1
    AST_ONE_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready); // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |=> !rsp_valid); // R4
    AST_NO_OE_IN_WRITE: assert property (@(posedge clk) disable iff (rst)
        !sram_we_n |-> (sram_oe_n && !sram_ce_n)); // R5
    AST_DRIVE_IN_PULSE: assert property (@(posedge clk) disable iff (rst)
        sram_dq_oe |-> (!sram_we_n && sram_oe_n && $past(!sram_we_n))); // R6
    AST_RELEASE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sram_we_n) |-> !sram_dq_oe); // R6
    AST_TURN_GAP: assert property (@(posedge clk) disable iff (rst)
        $past(!sram_oe_n) |-> !sram_dq_oe); // R8
    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (!sram_ce_n && $past(!sram_ce_n)) |-> ($stable(sram_addr) && $stable(sram_be_n))); // R9
endmodule

// File: tb/sim_sram_ctrl.sv
module sim_sram_ctrl;
    localparam int RW = 3, WP = 4, DS = 2, TURN = 2, PWR = 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic        req_ready, rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] sram_addr;
    logic        sram_ce_n, sram_we_n, sram_oe_n, sram_dq_oe;
    logic [1:0]  sram_be_n;
    logic [15:0] sram_dq_out;
    logic [15:0] sram_dq_in = 16'hA5A5;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    sram_ctrl #(.RD_WAIT_CYC(RW), .WE_PULSE_CYC(WP), .DATA_SETUP_CYC(DS),
                .TURN_CYC(TURN), .PWRUP_CYC(PWR)) u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
        .req_be(req_be), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n), .sram_we_n(sram_we_n),
        .sram_oe_n(sram_oe_n), .sram_be_n(sram_be_n), .sram_dq_out(sram_dq_out),
        .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] init_word(input logic [17:0] a);
        return 16'(a * 18'h09E37) ^ 16'h5A5A;
    endfunction

    logic [15:0] memarr [logic [17:0]];
    logic [15:0] shadow [logic [17:0]];

    function automatic logic [15:0] mem_get(input logic [17:0] a);
        return memarr.exists(a) ? memarr[a] : init_word(a);
    endfunction
    function automatic logic [15:0] sh_get(input logic [17:0] a);
        return shadow.exists(a) ? shadow[a] : init_word(a);
    endfunction

    // Behavioural memory with timing checks, evaluated away from the active edge.
    int rd_cnt = 0, we_cnt = 0, drv_cnt = 0, oe_gap = 100;
    bit prev_rd = 0, prev_wr = 0, prev_ce = 0, addr_moved = 0;
    logic [17:0] prev_addr = '0;
    logic [1:0]  prev_be = '1;
    logic [15:0] wlat = '0;

    always @(negedge clk) begin
        if (!rst) begin
            bit rd_act, wr_act;
            logic [15:0] w, nd;
            rd_act = !sram_ce_n && !sram_oe_n && sram_we_n;
            wr_act = !sram_ce_n && !sram_we_n;
            if (!sram_ce_n && prev_ce && (sram_addr != prev_addr || sram_be_n != prev_be))
                addr_moved = 1;
            // read path
            if (rd_act) rd_cnt = prev_rd ? rd_cnt + 1 : 1;
            else if (prev_rd) begin
                chk(rd_cnt == RW + 1, "R3 read strobe length", rd_cnt, RW + 1);
                rd_cnt = 0;
            end
            if (rd_act && rd_cnt >= RW + 1) begin
                w  = mem_get(sram_addr);
                nd = {sram_be_n[1] ? 8'hA5 : w[15:8], sram_be_n[0] ? 8'hA5 : w[7:0]};
            end else if (rd_act) nd = 16'hDEAD;
            else nd = 16'hA5A5;
            sram_dq_in = nd;
            // write path
            if (wr_act) begin
                we_cnt++;
                if (sram_dq_oe) begin
                    drv_cnt = (drv_cnt > 0 && sram_dq_out != wlat) ? 1 : drv_cnt + 1;
                    wlat = sram_dq_out;
                    if (we_cnt == 1) chk(0, "R6 bus driven in first strobe-low cycle", 1, 0);
                end
            end else if (prev_wr) begin
                chk(we_cnt == WP, "R5 write strobe width", we_cnt, WP);
                chk(drv_cnt == DS, "R6 data drive cycles", drv_cnt, DS);
                chk(!sram_dq_oe, "R6 drive released at strobe rise", sram_dq_oe, 0);
                chk(!sram_ce_n && sram_oe_n, "R5 release cycle strobes", {sram_ce_n, sram_oe_n}, 1);
                w = mem_get(sram_addr);
                if (!sram_be_n[0]) w[7:0] = wlat[7:0];
                if (!sram_be_n[1]) w[15:8] = wlat[15:8];
                memarr[sram_addr] = w;
                we_cnt = 0; drv_cnt = 0;
            end
            if (sram_dq_oe && !sram_oe_n) chk(0, "R8 drive while output enabled", 1, 0);
            if (sram_dq_oe && oe_gap < TURN) chk(0, "R8 turnaround gap", oe_gap, TURN);
            oe_gap = !sram_oe_n ? 0 : (oe_gap < 100 ? oe_gap + 1 : oe_gap);
            if (sram_ce_n && !prev_ce) begin
                chk(!addr_moved, "R9 address stable while selected", addr_moved, 0);
                addr_moved = 0;
            end
            prev_rd = rd_act; prev_wr = wr_act; prev_ce = !sram_ce_n;
            prev_addr = sram_addr; prev_be = sram_be_n;
        end
    end

    task automatic access(input bit wr, input logic [17:0] a, input logic [15:0] d,
                          input logic [1:0] be);
        int lat;
        logic [15:0] e, cur;
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_be = be;
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R2 ready drops after accept", req_ready, 0);
        chk(sram_be_n == ~be, "R7 byte enables follow mask", sram_be_n, ~be);
        lat = 1;
        while (!rsp_valid && lat < 60) begin @(negedge clk); lat++; end
        if (wr) begin
            // done after accepting edge plus WP+2 edges
            chk(lat == WP + 3, "R5 write done timing", lat, WP + 3);
            cur = sh_get(a);
            if (be[0]) cur[7:0] = d[7:0];
            if (be[1]) cur[15:8] = d[15:8];
            shadow[a] = cur;
        end else begin
            // done after accepting edge plus RW+1 edges
            chk(lat == RW + 2, "R3 read done timing", lat, RW + 2);
            cur = sh_get(a);
            e = {be[1] ? cur[15:8] : 8'h00, be[0] ? cur[7:0] : 8'h00};
            chk(rsp_rdata == e, "R4 R7 read data", rsp_rdata, e);
        end
        @(negedge clk);
        chk(!rsp_valid, "R4 done lasts one cycle", rsp_valid, 0);
        if (!wr) begin
            lat = 1;
            while (!req_ready && lat < 20) begin
                chk(sram_oe_n, "R8 output enable high in turnaround", sram_oe_n, 1);
                @(negedge clk); lat++;
            end
            chk(lat == TURN, "R8 turnaround length", lat, TURN);
        end
    endtask

    task automatic run_all();
        int cyc;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst = 0;
        chk(sram_ce_n && sram_we_n && sram_oe_n && sram_be_n == 2'b11 && !sram_dq_oe
            && !req_ready && !rsp_valid, "R1 reset state", 0, 0);
        // R2: a write offered during power-up must be ignored
        req_valid = 1; req_write = 1; req_addr = 18'h5; req_wdata = 16'hFFFF; req_be = 2'b11;
        cyc = 0;
        while (!req_ready && cyc < PWR + 10) begin
            if (cyc == PWR - 2) req_valid = 0;
            chk(sram_ce_n && !sram_dq_oe, "R1 quiet during power-up", sram_ce_n, 1);
            @(negedge clk); cyc++;
        end
        chk(cyc == PWR, "R1 power-up length", cyc, PWR);
        access(0, 18'h5, 0, 2'b11);
        access(1, 18'h10, 16'h1234, 2'b11);
        access(0, 18'h10, 0, 2'b11);
        access(1, 18'h10, 16'hABCD, 2'b01);   // R7 low byte only
        access(0, 18'h10, 0, 2'b11);
        access(1, 18'h10, 16'h5678, 2'b10);   // R7 high byte only
        access(1, 18'h10, 16'hFFFF, 2'b00);   // R7 empty mask
        access(0, 18'h10, 0, 2'b11);
        access(0, 18'h10, 0, 2'b01);          // R4 masked lane reads zero
        access(0, 18'h10, 0, 2'b00);
        access(1, 18'h3FFFF, 16'hC3E1, 2'b11);
        access(0, 18'h3FFFF, 0, 2'b11);
        // R2: request held while busy is ignored
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = 0; req_addr = 18'h20; req_be = 2'b11;
        @(negedge clk);
        req_write = 1; req_addr = 18'h21; req_wdata = 16'hEEEE;
        chk(!req_ready, "R2 ready low while busy", req_ready, 0);
        @(negedge clk); @(negedge clk);
        req_valid = 0;
        access(0, 18'h21, 0, 2'b11);
        for (int i = 0; i < 120; i++) begin
            logic [17:0] a;
            a = ($urandom % 2) ? {10'h000, 8'($urandom)} : {10'h3FF, 8'($urandom % 16)};
            access(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
        end
    endtask

    initial begin
        fork
            run_all();
            begin
                repeat (100000) @(posedge clk);
                chk(0, "R2 watchdog expired", 1, 0);
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule